// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block receives configuration words over a three-pin serial link (serial clock, serial data, load strobe) and holds them in three parallel configuration registers for the logic around it. A word is 24 bits long and arrives most significant bit first. Each rising serial-clock edge shifts one bit into a 24-bit shift register. A rising edge of the load strobe then commits the word.

When the word is committed, its two lowest bits act as a destination code. They pick one of three registers: the control register, the N-counter register or the R-counter register. The upper 22 bits are copied into the chosen register. The fourth code value selects nothing. Each register has a valid flag that rises on its first write.

The three serial pins are asynchronous to the system clock. They pass through a synchronizer and are edge-detected in the system clock domain. Serial timing therefore only has to meet minimum pulse, setup and hold limits measured against a system clock of at most 10 ns period.

Top module: `cfg3w_port`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it is sampled, all three registers read zero, all valid flags are low and the shift register clears.
- R2: Bits are taken on rising edges of `ser_clk`, most significant bit first. The committed word is always the last 24 bits shifted in: a longer frame keeps only its final 24 bits, and a shorter frame combines with bits that are already in the shift register.
- R3: No register or valid flag changes unless a rising edge of `ser_le` is seen. Shifting alone leaves every output unchanged.
- R4: On a commit, word bits [1:0] select the destination. Code 00 selects the control register, 10 selects the N-counter register and 01 selects the R-counter register. The destination receives word bits [23:2].
- R5: A commit with code 11 changes no register and no valid flag.
- R6: A commit changes only the register its code selects. The other two registers keep their values.
- R7: A register's valid flag goes high on its first write and stays high until reset.
- R8: One commit happens per rising edge of `ser_le`. Bits shifted in while `ser_le` stays high are not committed until the strobe falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, period at most 10 ns |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; its rising edge commits the word |
| ctrl_word | output | 22 | Control register contents |
| ncnt_word | output | 22 | N-counter register contents |
| rcnt_word | output | 22 | R-counter register contents |
| ctrl_valid | output | 1 | Control register has been written |
| ncnt_valid | output | 1 | N-counter register has been written |
| rcnt_valid | output | 1 | R-counter register has been written |

## Verification
The bound checker checks the following on every cycle:
- the reset clearing of the registers and flags;
- that nothing changes without a detected commit;
- that each destination code loads exactly its own register with the payload of the word being committed, and that code 11 loads nothing;
- that a valid flag, once high, stays high.

The following depend on pin-level sequences, so only the bench scenarios can show them:
- MSB-first ordering and word assembly across overlong and short frames;
- a single commit for a strobe held high while new bits arrive;
- compliance of the driven serial waveform with the minimum timing limits.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;

    localparam int WORD_W   = 24;
    localparam int ADDR_W   = 2;
    localparam int PAY_W    = WORD_W - ADDR_W;
    localparam int NUM_DEST = 3;

    localparam int IDX_CTRL = 0;
    localparam int IDX_NCNT = 1;
    localparam int IDX_RCNT = 2;

    // Destination code carried in the two lowest word bits
    typedef enum logic [ADDR_W-1:0] {
        DEST_CTRL  = 2'b00,
        DEST_RCNT  = 2'b01,
        DEST_NCNT  = 2'b10,
        DEST_SPARE = 2'b11
    } dest_e;

    // Field order matches bit order of the serial word: payload high, code low
    typedef struct packed {
        logic [PAY_W-1:0] payload;
        dest_e            dest;
    } frame_t;

    function automatic logic [NUM_DEST-1:0] dest_onehot(input dest_e d);
        logic [NUM_DEST-1:0] sel;
        sel = '0;
        case (d)
            DEST_CTRL: sel[IDX_CTRL] = 1'b1;
            DEST_NCNT: sel[IDX_NCNT] = 1'b1;
            DEST_RCNT: sel[IDX_RCNT] = 1'b1;
            default:   sel = '0;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= din;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/cfg3w_shift.sv
module cfg3w_shift
    import cfg3w_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk_s,
    input  logic   sdata_s,
    input  logic   le_s,
    output frame_t frame,
    output logic   load
);

    logic              sclk_d;
    logic              le_d;
    logic [WORD_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            le_d   <= 1'b0;
            sr     <= '0;
        end else begin
            sclk_d <= sclk_s;
            le_d   <= le_s;
            if (sclk_s && !sclk_d) sr <= {sr[WORD_W-2:0], sdata_s};
        end
    end

    assign load  = le_s && !le_d;
    assign frame = frame_t'(sr);

endmodule

// File: rtl/cfg3w_bank.sv
module cfg3w_bank
    import cfg3w_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           load,
    input  frame_t                         frame,
    output logic [NUM_DEST-1:0][PAY_W-1:0] q,
    output logic [NUM_DEST-1:0]            vld
);

    logic [NUM_DEST-1:0] sel;

    always_comb sel = dest_onehot(frame.dest);

    for (genvar i = 0; i < NUM_DEST; i++) begin : g_reg
        logic [PAY_W-1:0] r;
        logic             v;
        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
                v <= 1'b0;
            end else if (load && sel[i]) begin
                r <= frame.payload;
                v <= 1'b1;
            end
        end
        assign q[i]   = r;
        assign vld[i] = v;
    end

endmodule

// File: rtl/cfg3w_port.sv
module cfg3w_port
    import cfg3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_le,
    output logic [PAY_W-1:0] ctrl_word,
    output logic [PAY_W-1:0] ncnt_word,
    output logic [PAY_W-1:0] rcnt_word,
    output logic             ctrl_valid,
    output logic             ncnt_valid,
    output logic             rcnt_valid
);

    logic [2:0]                     pins_s;
    frame_t                         cur_frame;
    logic                           load_pulse;
    logic [NUM_DEST-1:0][PAY_W-1:0] bank_q;
    logic [NUM_DEST-1:0]            bank_v;

    cfg3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ser_le, ser_data, ser_clk}),
        .dout (pins_s)
    );

    cfg3w_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (pins_s[0]),
        .sdata_s (pins_s[1]),
        .le_s    (pins_s[2]),
        .frame   (cur_frame),
        .load    (load_pulse)
    );

    cfg3w_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .load  (load_pulse),
        .frame (cur_frame),
        .q     (bank_q),
        .vld   (bank_v)
    );

    assign ctrl_word  = bank_q[IDX_CTRL];
    assign ncnt_word  = bank_q[IDX_NCNT];
    assign rcnt_word  = bank_q[IDX_RCNT];
    assign ctrl_valid = bank_v[IDX_CTRL];
    assign ncnt_valid = bank_v[IDX_NCNT];
    assign rcnt_valid = bank_v[IDX_RCNT];

endmodule

// File: rtl/cfg3w_port_chk.sv
module cfg3w_port_chk
    import cfg3w_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             load,
    input frame_t           frame,
    input logic [PAY_W-1:0] ctrl_word,
    input logic [PAY_W-1:0] ncnt_word,
    input logic [PAY_W-1:0] rcnt_word,
    input logic             ctrl_valid,
    input logic             ncnt_valid,
    input logic             rcnt_valid
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (ctrl_word == '0 && ncnt_word == '0 && rcnt_word == '0 &&
                 !ctrl_valid && !ncnt_valid && !rcnt_valid)); // R1

    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(ctrl_word) && $stable(ncnt_word) && $stable(rcnt_word) &&
                   $stable(ctrl_valid) && $stable(ncnt_valid) && $stable(rcnt_valid))); // R3

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (load && frame.dest == DEST_CTRL) |=>
            (ctrl_word == $past(frame.payload) && ctrl_valid &&
             $stable(ncnt_word) && $stable(rcnt_word))); // R4

    AST_NCNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (load && frame.dest == DEST_NCNT) |=>
            (ncnt_word == $past(frame.payload) && ncnt_valid &&
             $stable(ctrl_word) && $stable(rcnt_word))); // R6

    AST_RCNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (load && frame.dest == DEST_RCNT) |=>
            (rcnt_word == $past(frame.payload) && rcnt_valid &&
             $stable(ctrl_word) && $stable(ncnt_word))); // R6

    AST_SPARE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (load && frame.dest == DEST_SPARE) |=>
            ($stable(ctrl_word) && $stable(ncnt_word) && $stable(rcnt_word) &&
             $stable(ctrl_valid) && $stable(ncnt_valid) && $stable(rcnt_valid))); // R5

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctrl_valid || ncnt_valid || rcnt_valid) |=>
            (($past(ctrl_valid) -> ctrl_valid) && ($past(ncnt_valid) -> ncnt_valid) &&
             ($past(rcnt_valid) -> rcnt_valid))); // R7

endmodule

bind cfg3w_port cfg3w_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .load       (load_pulse),
    .frame      (cur_frame),
    .ctrl_word  (ctrl_word),
    .ncnt_word  (ncnt_word),
    .rcnt_word  (rcnt_word),
    .ctrl_valid (ctrl_valid),
    .ncnt_valid (ncnt_valid),
    .rcnt_valid (rcnt_valid)
);

// File: tb/cfg3w_port_bench.sv
`timescale 1ns/1ps
module cfg3w_port_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_le = 1'b0;
    logic [21:0] ctrl_word, ncnt_word, rcnt_word;
    logic        ctrl_valid, ncnt_valid, rcnt_valid;

    int checks = 0;
    int errors = 0;
    int tviol  = 0;
    bit done   = 1'b0;

    // bench model: shift register, registers, valid flags
    logic [23:0] m_sr = '0;
    logic [21:0] m_q [3];
    logic [2:0]  m_v;

    localparam int NVEC = 8;
    localparam logic [23:0] VEC [NVEC] = '{
        24'hABCDE0, 24'h123456, 24'h0F0F0D, 24'hFFFFFF,
        24'h5A5A5C, 24'h800002, 24'h7FFFFD, 24'h000003
    };

    always #5 clk = ~clk;

    cfg3w_port u_cfg3w_port (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .ctrl_word(ctrl_word), .ncnt_word(ncnt_word), .rcnt_word(rcnt_word),
        .ctrl_valid(ctrl_valid), .ncnt_valid(ncnt_valid), .rcnt_valid(rcnt_valid)
    );

    // serial timing monitor against the minimum limits
    realtime t_data = -1000.0, t_rise = -1000.0, t_fall = -1000.0, t_le = -1000.0;
    always @(ser_data) begin
        if (ser_clk && ($realtime - t_rise) < 10.0) tviol++;
        t_data = $realtime;
    end
    always @(posedge ser_clk) begin
        if (($realtime - t_data) < 10.0 || ($realtime - t_fall) < 25.0) tviol++;
        t_rise = $realtime;
    end
    always @(negedge ser_clk) begin
        if (($realtime - t_rise) < 25.0) tviol++;
        t_fall = $realtime;
    end
    always @(posedge ser_le) begin
        if (($realtime - t_rise) < 10.0) tviol++;
        t_le = $realtime;
    end
    always @(negedge ser_le) begin
        if (($realtime - t_le) < 20.0) tviol++;
    end

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            #20 ser_clk = 1'b1;
            m_sr = {m_sr[22:0], v[i]};
            #30 ser_clk = 1'b0;
            #10;
        end
    endtask

    task automatic model_load();
        case (m_sr[1:0])
            2'b00: begin m_q[0] = m_sr[23:2]; m_v[0] = 1'b1; end
            2'b10: begin m_q[1] = m_sr[23:2]; m_v[1] = 1'b1; end
            2'b01: begin m_q[2] = m_sr[23:2]; m_v[2] = 1'b1; end
            default: ;
        endcase
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_le();
        #20 ser_le = 1'b1;
        #30 ser_le = 1'b0;
        model_load();
        settle();
    endtask

    task automatic check_all(input string tag);
        checks++;
        if (ctrl_word !== m_q[0] || ctrl_valid !== m_v[0]) begin
            errors++;
            $display("FAIL %s control: got %h/%b expected %h/%b", tag, ctrl_word, ctrl_valid, m_q[0], m_v[0]);
        end
        checks++;
        if (ncnt_word !== m_q[1] || ncnt_valid !== m_v[1]) begin
            errors++;
            $display("FAIL %s N-counter: got %h/%b expected %h/%b", tag, ncnt_word, ncnt_valid, m_q[1], m_v[1]);
        end
        checks++;
        if (rcnt_word !== m_q[2] || rcnt_valid !== m_v[2]) begin
            errors++;
            $display("FAIL %s R-counter: got %h/%b expected %h/%b", tag, rcnt_word, rcnt_valid, m_q[2], m_v[2]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (4) @(negedge clk);
        m_sr = '0;
        foreach (m_q[k]) m_q[k] = '0;
        m_v = '0;
    endtask

    initial begin
        do_reset();
        check_all("R1 reset");
        rst = 1'b0;
        settle();

        // table walk: one word per entry
        for (int i = 0; i < NVEC; i++) begin
            shift_bits({8'h00, VEC[i]}, 24);
            pulse_le();
            check_all((VEC[i][1:0] == 2'b11) ? "R5 spare code" : "R4 R6 R7 decode");
        end

        // shifting alone commits nothing
        shift_bits({8'h00, 24'h3C3C38}, 24);
        settle();
        check_all("R3 shift without strobe");
        pulse_le();
        check_all("R3 strobe alone commits");

        // overlong frame keeps the last 24 bits
        shift_bits(32'hDEADBEEE, 32);
        pulse_le();
        check_all("R2 overlong frame");

        // short frame mixes with held bits
        shift_bits(32'h0000_0096, 8);
        pulse_le();
        check_all("R2 short frame");

        // strobe held high while a new word arrives
        shift_bits({8'h00, 24'h111112}, 24);
        #20 ser_le = 1'b1;
        model_load();
        settle();
        shift_bits({8'h00, 24'h222221}, 24);
        settle();
        check_all("R8 held strobe no second commit");
        ser_le = 1'b0;
        settle();
        check_all("R8 strobe fall commits nothing");
        pulse_le();
        check_all("R8 next rising edge commits");

        // reset in mid-operation
        do_reset();
        check_all("R1 reset after writes");
        rst = 1'b0;
        settle();
        shift_bits({8'h00, 24'h000001}, 24);
        pulse_le();
        check_all("R7 first write after reset");

        checks++;
        if (tviol != 0) begin
            errors++;
            $display("FAIL timing limits: got %0d violations expected 0", tviol);
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule